// File: doc/BRIEF.md
# Dot-Matrix Row Refresh with Cursor Substitution

This block refreshes a row of four character cells, each a grid five columns wide and seven rows tall, through a shared set of row drivers. A row index steps forward on every refresh tick. Each time it moves, the block registers the four stored character codes together with the new row index and presents them to an external glyph lookup. That lookup returns five column bits per digit within the same cycle. On the next clock edge the block latches those columns, unless a digit is marked for a cursor. A marked digit gets a solid block of lit dots in place of its character.

The cursor is meant to look half as bright as a character. To get that effect, cursor columns are lit only on alternate refresh frames. A frame parity bit toggles each time the row index wraps. A cursor-enable input acts as the master switch for all cursor substitution. During the one cycle in which new column data is being fetched, the row select is held all zero so that the previous row's dots do not ghost onto the new row. The font contents and any brightness gating are outside this block.

Top module: `dotrow_refresh`

## Requirements
- R1: While reset is high, and afterwards until the first tick, `row_sel` and `col_out` are zero and `glyph_row` is 6. The first tick after reset selects row 0.
- R2: Each cycle with `row_tick` high advances `glyph_row` by one, wrapping from 6 to 0. Without a tick, `glyph_row` holds. The value 7 never appears.
- R3: In the cycle after a tick, `glyph_code` equals `char_codes` as sampled at the tick edge, `glyph_row` shows the new row, and `row_sel` is all zero.
- R4: From the cycle after that until the next tick, `row_sel` has only bit r set, where r is the current row. Digit d of `col_out` (bits 5d+4..5d, digit 0 in the low slice) holds the `glyph_cols` slice d captured at the end of the loading cycle, unless R6 applies.
- R5: When `cursor_en` is 0 at the capture edge, every digit shows its glyph columns whatever the values of `cursor_bits`.
- R6: When `cursor_en` is 1 and `cursor_bits[d]` is 1 at the capture edge, digit d shows 5'b11111 on even frames and 5'b00000 on odd frames. Unmarked digits still show their glyphs.
- R7: The frame parity flips each time the row wraps from 6 to 0. The frame that starts with the first tick after reset is even.
- R8: `row_sel` never has more than one bit set. When it is nonzero, its set bit matches `glyph_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_codes | input | 28 | Four 7-bit character codes, digit 0 in bits 6..0 |
| cursor_bits | input | 4 | Per-digit cursor marks |
| cursor_en | input | 1 | Master enable for cursor substitution |
| row_tick | input | 1 | Advance to the next row |
| glyph_code | output | 28 | Registered character codes sent to the lookup |
| glyph_row | output | 3 | Registered row index sent to the lookup |
| glyph_cols | input | 20 | Column bits returned by the lookup, five per digit |
| row_sel | output | 7 | One-hot row drive, zero while loading |
| col_out | output | 20 | Column drive, five bits per digit |

## Verification
The bench walks full frames across the 6-to-0 wrap and checks three things. It confirms that the row index never lands on 7, which would happen in a design that wraps at the counter width. It confirms that each row's columns carry that row's glyph rather than the previous one, which would happen in a design with an off-by-one capture. It confirms that the row drive drops to zero in the loading cycle, which a ghosting design would fail. With cursor marks set, it runs two consecutive frames to show that marked digits alternate between fully lit and dark while unmarked digits keep their glyphs. A design that toggled parity on every row, or never toggled it, would fail this check. It also sets cursor marks while the enable is low, where a leaking multiplexer would put the block on screen.

// File: rtl/dotrow_pkg.sv
package dotrow_pkg;

    localparam int DEF_DIGITS = 4;
    localparam int DEF_COLS   = 5;
    localparam int DEF_ROWS   = 7;
    localparam int DEF_CODE_W = 7;

    typedef enum logic [1:0] {
        PH_DARK = 2'd0,
        PH_LOAD = 2'd1,
        PH_SHOW = 2'd2
    } phase_e;

endpackage

// File: rtl/dotrow_sequencer.sv
module dotrow_sequencer
    import dotrow_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_odd,
    output phase_e           phase
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic wrap;
    assign wrap = (row_idx == LAST_ROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_idx   <= LAST_ROW;
            frame_odd <= 1'b1;
            phase     <= PH_DARK;
        end else if (tick) begin
            row_idx <= wrap ? '0 : row_idx + ROW_W'(1);
            if (wrap) frame_odd <= ~frame_odd;
            phase <= PH_LOAD;
        end else if (phase == PH_LOAD) begin
            phase <= PH_SHOW;
        end
    end
endmodule

// File: rtl/dotrow_glyph_req.sv
module dotrow_glyph_req
    import dotrow_pkg::*;
#(
    parameter int DIGITS = DEF_DIGITS,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic [DIGITS*CODE_W-1:0] codes_in,
    output logic [DIGITS*CODE_W-1:0] codes_req
);
    always_ff @(posedge clk) begin
        if (rst)       codes_req <= '0;
        else if (tick) codes_req <= codes_in;
    end
endmodule

// File: rtl/dotrow_col_select.sv
module dotrow_col_select
    import dotrow_pkg::*;
#(
    parameter int DIGITS = DEF_DIGITS,
    parameter int COLS   = DEF_COLS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  phase_e                 phase,
    input  logic                   frame_odd,
    input  logic                   cursor_en,
    input  logic [DIGITS-1:0]      cursor_bits,
    input  logic [DIGITS*COLS-1:0] glyph_cols,
    output logic [DIGITS*COLS-1:0] cols_q
);
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic            use_cursor;
        logic [COLS-1:0] next_cols;

        assign use_cursor = cursor_en & cursor_bits[d];
        assign next_cols  = use_cursor ? {COLS{~frame_odd}}
                                       : glyph_cols[d*COLS +: COLS];

        always_ff @(posedge clk) begin
            if (rst)                  cols_q[d*COLS +: COLS] <= '0;
            else if (phase == PH_LOAD) cols_q[d*COLS +: COLS] <= next_cols;
        end
    end
endmodule

// File: rtl/dotrow_refresh.sv
module dotrow_refresh
    import dotrow_pkg::*;
#(
    parameter int DIGITS = DEF_DIGITS,
    parameter int COLS   = DEF_COLS,
    parameter int ROWS   = DEF_ROWS,
    parameter int CODE_W = DEF_CODE_W,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIGITS*CODE_W-1:0] char_codes,
    input  logic [DIGITS-1:0]        cursor_bits,
    input  logic                     cursor_en,
    input  logic                     row_tick,
    output logic [DIGITS*CODE_W-1:0] glyph_code,
    output logic [ROW_W-1:0]         glyph_row,
    input  logic [DIGITS*COLS-1:0]   glyph_cols,
    output logic [ROWS-1:0]          row_sel,
    output logic [DIGITS*COLS-1:0]   col_out
);
    phase_e phase;
    logic   frame_odd;

    dotrow_sequencer #(.ROWS(ROWS), .ROW_W(ROW_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (row_tick),
        .row_idx   (glyph_row),
        .frame_odd (frame_odd),
        .phase     (phase)
    );

    dotrow_glyph_req #(.DIGITS(DIGITS), .CODE_W(CODE_W)) req_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (row_tick),
        .codes_in  (char_codes),
        .codes_req (glyph_code)
    );

    dotrow_col_select #(.DIGITS(DIGITS), .COLS(COLS)) sel_i (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .frame_odd   (frame_odd),
        .cursor_en   (cursor_en),
        .cursor_bits (cursor_bits),
        .glyph_cols  (glyph_cols),
        .cols_q      (col_out)
    );

    always_comb begin
        row_sel = '0;
        if (phase == PH_SHOW) row_sel[glyph_row] = 1'b1;
    end
endmodule

// File: rtl/dotrow_refresh_chk.sv
module dotrow_refresh_chk #(
    parameter int ROWS  = 7,
    parameter int ROW_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst,
    input logic             row_tick,
    input logic [ROW_W-1:0] glyph_row,
    input logic [ROWS-1:0]  row_sel
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    p_row_range_r2: assert property (@(posedge clk) disable iff (rst)
        glyph_row <= LAST_ROW);

    p_row_step_r2: assert property (@(posedge clk) disable iff (rst)
        (row_tick && glyph_row != LAST_ROW) |=> glyph_row == $past(glyph_row) + ROW_W'(1));

    p_row_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (row_tick && glyph_row == LAST_ROW) |=> glyph_row == '0);

    p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !row_tick |=> $stable(glyph_row));

    p_dark_on_load_r3: assert property (@(posedge clk) disable iff (rst)
        row_tick |=> row_sel == '0);

    p_show_after_load_r4: assert property (@(posedge clk) disable iff (rst)
        row_tick ##1 !row_tick |=> row_sel != '0);

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel));

    p_row_match_r8: assert property (@(posedge clk) disable iff (rst)
        row_sel != '0 |-> row_sel == (ROWS'(1) << glyph_row));
endmodule

bind dotrow_refresh dotrow_refresh_chk #(.ROWS(ROWS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .row_tick  (row_tick),
    .glyph_row (glyph_row),
    .row_sel   (row_sel)
);

// File: tb/dotrow_refresh_tb.sv
`timescale 1ns/1ps
module dotrow_refresh_tb_top;
    localparam int DIGITS = 4;
    localparam int COLS   = 5;
    localparam int ROWS   = 7;
    localparam int CODE_W = 7;

    logic                     clk = 1'b0;
    logic                     rst;
    logic [DIGITS*CODE_W-1:0] char_codes;
    logic [DIGITS-1:0]        cursor_bits;
    logic                     cursor_en;
    logic                     row_tick;
    logic [DIGITS*CODE_W-1:0] glyph_code;
    logic [2:0]               glyph_row;
    logic [DIGITS*COLS-1:0]   glyph_cols;
    logic [ROWS-1:0]          row_sel;
    logic [DIGITS*COLS-1:0]   col_out;

    int checks = 0;
    int errors = 0;
    int exp_row;
    bit exp_odd;

    always #2.5 clk = ~clk;

    dotrow_refresh dut_i (
        .clk(clk), .rst(rst), .char_codes(char_codes), .cursor_bits(cursor_bits),
        .cursor_en(cursor_en), .row_tick(row_tick), .glyph_code(glyph_code),
        .glyph_row(glyph_row), .glyph_cols(glyph_cols), .row_sel(row_sel),
        .col_out(col_out)
    );

    function automatic logic [COLS-1:0] font(input logic [CODE_W-1:0] c, input logic [2:0] r);
        return c[4:0] ^ {r, 2'b01} ^ {4'b0, c[6]};
    endfunction

    always_comb begin
        for (int d = 0; d < DIGITS; d++)
            glyph_cols[d*COLS +: COLS] = font(glyph_code[d*CODE_W +: CODE_W], glyph_row);
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DIGITS*COLS-1:0] expect_cols(input int r);
        logic [DIGITS*COLS-1:0] v;
        for (int d = 0; d < DIGITS; d++) begin
            if (cursor_en && cursor_bits[d])
                v[d*COLS +: COLS] = exp_odd ? 5'b00000 : 5'b11111;
            else
                v[d*COLS +: COLS] = font(char_codes[d*CODE_W +: CODE_W], 3'(r));
        end
        return v;
    endfunction

    task automatic do_row(input string tag);
        @(negedge clk);
        row_tick = 1'b1;
        if (exp_row == ROWS - 1) begin
            exp_row = 0;
            exp_odd = ~exp_odd;
        end else begin
            exp_row++;
        end
        @(negedge clk);
        row_tick = 1'b0;
        check(row_sel == '0, {tag, " R3 dark while loading"}, 32'(row_sel), 0);
        check(glyph_row == 3'(exp_row), {tag, " R2 row index"}, 32'(glyph_row), 32'(exp_row));
        check(glyph_code == char_codes, {tag, " R3 request codes"}, 32'(glyph_code), 32'(char_codes));
        @(negedge clk);
        check(row_sel == (7'd1 << exp_row), {tag, " R4 R8 row select"}, 32'(row_sel), 32'(1 << exp_row));
        check(col_out == expect_cols(exp_row), {tag, " R4 columns"}, 32'(col_out), 32'(expect_cols(exp_row)));
        @(negedge clk);
        check(col_out == expect_cols(exp_row), {tag, " R4 columns held"}, 32'(col_out), 32'(expect_cols(exp_row)));
    endtask

    task automatic t_reset();
        rst = 1'b1; row_tick = 1'b0; cursor_en = 1'b0; cursor_bits = '0;
        char_codes = {7'h00, 7'h7F, 7'h35, 7'h41};
        exp_row = ROWS - 1; exp_odd = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(row_sel == '0, "R1 row_sel after reset", 32'(row_sel), 0);
        check(col_out == '0, "R1 col_out after reset", 32'(col_out), 0);
        check(glyph_row == 3'd6, "R1 glyph_row after reset", 32'(glyph_row), 6);
    endtask

    task automatic t_walk_chars();
        for (int i = 0; i < ROWS; i++) do_row("walk");
        check(exp_odd == 1'b0, "R7 first frame even", 32'(exp_odd), 0);
    endtask

    task automatic t_wrap();
        char_codes = {7'h5A, 7'h12, 7'h6C, 7'h03};
        for (int i = 0; i < ROWS + 2; i++) do_row("wrap");
        check(glyph_row == 3'd1, "R2 wrap past 6", 32'(glyph_row), 1);
    endtask

    task automatic t_cursor_disabled();
        cursor_en = 1'b0; cursor_bits = 4'b1111;
        for (int i = 0; i < ROWS; i++) do_row("R5 cursor ignored");
    endtask

    task automatic t_cursor_half();
        cursor_en = 1'b1; cursor_bits = 4'b0101;
        char_codes = {7'h2A, 7'h11, 7'h47, 7'h60};
        for (int i = 0; i < 2 * ROWS; i++) do_row("R6 R7 cursor");
        cursor_bits = 4'b1000;
        for (int i = 0; i < ROWS; i++) do_row("R6 cursor digit3");
    endtask

    initial begin
        t_reset();
        t_walk_chars();
        t_wrap();
        t_cursor_disabled();
        t_cursor_half();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule